// File: doc/BRIEF.md
# Burst Link Test Sequencer

This block produces a repeating, fixed-period transmit pattern for measuring how long a reconfigurable burst-mode optical link is unusable after each switch event. Each period starts with a one-word pulse that latches a new state into a 2x2 optical switch and flips the switch-state bit. A run of all-zero words follows while the switch settles. Next comes an alternating-bit preamble, which lets the burst-mode receiver recover its clock. Then comes a pseudo-random payload that a downstream checker can predict. Any words left before the next period are zero again and act as the trailing guard.

All lengths are counted in parallel-word clocks. The period, the switch-to-preamble delay, the preamble length and the payload length each come from their own configuration input. The block samples these inputs once, on the first word of each period. A cycle marker on that first word lets a gated error detector align its window to the payload.

Top module: `burst_cycle_seq`

## Requirements
- R1: While reset is held, the data word is zero, the switch-state bit is 0, and neither the latch strobe nor the cycle marker is asserted.
- R2: After the first clock edge with the enable high, the first word of a period is presented. The latch strobe and the cycle marker are high together, on that word only, and again every period length words while the enable stays high.
- R3: The switch-state bit inverts on the first word of each period and holds its value on every other word.
- R4: Word indices 0 up to (but not including) the switch delay carry all zeros.
- R5: The next preamble-length words carry the alternating pattern 32'hAAAAAAAA.
- R6: The next payload-length words carry PRBS31 data, 32 bits per word. The generator is restarted from seed 31'h2ACE5EED at the first payload word of every period. Each bit is b = s[30]^s[27], after which the state shifts to {s[29:0], b}. The first bit generated is placed in bit 31 of the word.
- R7: Words after the payload, up to the end of the period, carry all zeros.
- R8: Each segment is cut off at the period boundary. A word index never reaches the period length, so a delay at least as long as the period gives a period of all zeros.
- R9: The configuration inputs are sampled only on the first word of a period. A change made part-way through a period takes effect from the next period.
- R10: When the enable is seen low at a clock edge, the next word is zero with no strobes, and the switch-state bit holds. Raising the enable again begins a fresh period at word 0, which again flips the switch bit.
- R11: A period length of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Enable; periods repeat while high |
| cfgCycleLen | input | 16 | Period length in words |
| cfgSwDelay | input | 16 | Zero words after the latch before the preamble |
| cfgPreLen | input | 16 | Preamble length in words |
| cfgPayLen | input | 16 | Payload length in words |
| dataWord | output | 32 | Parallel transmit word |
| swCtrl | output | 1 | Switch-state bit |
| swLatch | output | 1 | Switch latch strobe, first word of each period |
| cycleStart | output | 1 | Period marker, first word of each period |

## Verification
Every output belongs to the word selected by the registers updated at the preceding clock edge. Enabling, changing the configuration or disabling therefore becomes visible on the word right after the next rising edge, with no extra pipeline stage. The bench drives inputs on the falling edge and checks the following falling edge, so each check lines up with exactly one new word. Its model keeps its own word index and its own sampled configuration, and captures that configuration when its index reaches 0. This matches the rule that settings are taken at the same edge that presents the first word.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    PH_OFF = 2'd0,
    PH_GAP = 2'd1,
    PH_PRE = 2'd2,
    PH_PAY = 2'd3
  } phase_e;

  // Control to datapath strobes
  typedef struct packed {
    logic   newCycle;   // next edge begins word 0
    logic   firstWord;  // current word is word 0
    phase_e phase;      // segment of the current word
  } seq_strobe_t;

  localparam int PRBS_W = 31;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [LEN_W-1:0] cfgCycleLen,
  input  logic [LEN_W-1:0] cfgSwDelay,
  input  logic [LEN_W-1:0] cfgPreLen,
  input  logic [LEN_W-1:0] cfgPayLen,
  output seq_strobe_t      strobes
);

  localparam int SUM_W = LEN_W + 2;

  logic             active;
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] cycLenQ;
  logic [LEN_W-1:0] swDelayQ;
  logic [LEN_W-1:0] preLenQ;
  logic [LEN_W-1:0] payLenQ;
  logic             lastWord;
  logic             startNext;
  logic [SUM_W-1:0] idxExt;
  logic [SUM_W-1:0] preStart;
  logic [SUM_W-1:0] payStart;
  logic [SUM_W-1:0] payEnd;
  phase_e           phaseNow;

  assign lastWord  = (idx == cycLenQ - LEN_W'(1));
  assign startNext = runEn && (!active || lastWord);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      idx      <= '0;
      cycLenQ  <= LEN_W'(1);
      swDelayQ <= '0;
      preLenQ  <= '0;
      payLenQ  <= '0;
    end else if (!runEn) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (startNext) begin
      active   <= 1'b1;
      idx      <= '0;
      cycLenQ  <= (cfgCycleLen == '0) ? LEN_W'(1) : cfgCycleLen;
      swDelayQ <= cfgSwDelay;
      preLenQ  <= cfgPreLen;
      payLenQ  <= cfgPayLen;
    end else begin
      idx <= idx + LEN_W'(1);
    end
  end

  // Segment boundaries measured from word 0
  assign idxExt   = SUM_W'(idx);
  assign preStart = SUM_W'(swDelayQ);
  assign payStart = preStart + SUM_W'(preLenQ);
  assign payEnd   = payStart + SUM_W'(payLenQ);

  always_comb begin
    if (!active)                phaseNow = PH_OFF;
    else if (idxExt < preStart) phaseNow = PH_GAP;
    else if (idxExt < payStart) phaseNow = PH_PRE;
    else if (idxExt < payEnd)   phaseNow = PH_PAY;
    else                        phaseNow = PH_GAP;
  end

  assign strobes.newCycle  = startNext;
  assign strobes.firstWord = active && (idx == '0);
  assign strobes.phase     = phaseNow;

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && runEn && !lastWord) |=> (idx == $past(idx) + LEN_W'(1)));

  // R8
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (idx < cycLenQ));

endmodule

// File: rtl/burst_seq_dpath.sv
module burst_seq_dpath
  import burst_seq_pkg::*;
#(
  parameter int              WORD_W = 32,
  parameter logic [PRBS_W-1:0] SEED = 31'h2ACE5EED
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobes,
  output logic [WORD_W-1:0] dataWord,
  output logic              swCtrl,
  output logic              swLatch,
  output logic              cycleStart
);

  localparam logic [WORD_W-1:0] PREAMBLE = {(WORD_W/2){2'b10}};
  localparam int RUN_W = WORD_W + PRBS_W;

  logic              swState;
  logic [PRBS_W-1:0] prbsState;
  logic [RUN_W-1:0]  prbsRunOut;
  logic [WORD_W-1:0] prbsWord;
  logic [PRBS_W-1:0] prbsNext;

  // Generate one word of PRBS31 (x^31 + x^28 + 1), first bit in the MSB
  function automatic logic [RUN_W-1:0] prbsRun(input logic [PRBS_W-1:0] seedIn);
    logic [PRBS_W-1:0] st;
    logic [WORD_W-1:0] w;
    logic              fb;
    st = seedIn;
    w  = '0;
    for (int i = 0; i < WORD_W; i++) begin
      fb = st[30] ^ st[27];
      st = {st[29:0], fb};
      w[WORD_W-1-i] = fb;
    end
    return {w, st};
  endfunction

  assign prbsRunOut = prbsRun(prbsState);
  assign prbsWord   = prbsRunOut[RUN_W-1:PRBS_W];
  assign prbsNext   = prbsRunOut[PRBS_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swState   <= 1'b0;
      prbsState <= SEED;
    end else begin
      if (strobes.newCycle) swState <= ~swState;
      if (strobes.phase == PH_PAY && !strobes.newCycle) prbsState <= prbsNext;
      else                                              prbsState <= SEED;
    end
  end

  always_comb begin
    case (strobes.phase)
      PH_PRE:  dataWord = PREAMBLE;
      PH_PAY:  dataWord = prbsWord;
      default: dataWord = '0;
    endcase
  end

  assign swCtrl     = swState;
  assign swLatch    = strobes.firstWord;
  assign cycleStart = strobes.firstWord;

  // R3
  sw_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(swState) |-> strobes.firstWord);

  // R6
  prbs_reseed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.phase == PH_PAY && $past(strobes.phase) != PH_PAY) |-> (prbsState == SEED));

endmodule

// File: rtl/burst_cycle_seq.sv
module burst_cycle_seq
  import burst_seq_pkg::*;
#(
  parameter int                LEN_W  = 16,
  parameter int                WORD_W = 32,
  parameter logic [PRBS_W-1:0] SEED   = 31'h2ACE5EED
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic [LEN_W-1:0]  cfgCycleLen,
  input  logic [LEN_W-1:0]  cfgSwDelay,
  input  logic [LEN_W-1:0]  cfgPreLen,
  input  logic [LEN_W-1:0]  cfgPayLen,
  output logic [WORD_W-1:0] dataWord,
  output logic              swCtrl,
  output logic              swLatch,
  output logic              cycleStart
);

  seq_strobe_t strobes;

  burst_seq_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .runEn      (runEn),
    .cfgCycleLen(cfgCycleLen),
    .cfgSwDelay (cfgSwDelay),
    .cfgPreLen  (cfgPreLen),
    .cfgPayLen  (cfgPayLen),
    .strobes    (strobes)
  );

  burst_seq_dpath #(.WORD_W(WORD_W), .SEED(SEED)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dataWord  (dataWord),
    .swCtrl    (swCtrl),
    .swLatch   (swLatch),
    .cycleStart(cycleStart)
  );

  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(runEn) |-> (dataWord == '0 && !cycleStart && !swLatch && $stable(swCtrl)));

endmodule

// File: tb/tb_burst_cycle_seq.sv
module tb_burst_cycle_seq;

  localparam int CLK_PERIOD = 10;
  localparam logic [30:0] SEED = 31'h2ACE5EED;

  // {cycle length, switch delay, preamble, payload}
  localparam int NVEC = 6;
  localparam int VEC [NVEC][4] = '{
    '{12, 2, 3, 4},   // guard after payload
    '{ 8, 0, 0, 8},   // payload only, back-to-back reseed
    '{10, 3, 2, 9},   // payload cut at period end
    '{ 6, 7, 2, 2},   // delay beyond period: all zeros
    '{ 1, 0, 1, 0},   // one-word period of preamble
    '{ 0, 0, 0, 1}    // length 0 behaves as 1
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic [15:0] cfgCycleLen = '0, cfgSwDelay = '0, cfgPreLen = '0, cfgPayLen = '0;
  logic [31:0] dataWord;
  logic        swCtrl, swLatch, cycleStart;

  int nChecks = 0;
  int nFails  = 0;
  string ctx = "";

  // bench model state
  int          k = 0;
  int          sCyc = 1, sSw = 0, sPre = 0, sPay = 0;
  logic        expSw = 1'b0;
  logic [30:0] pState = SEED;

  burst_cycle_seq dut (
    .clk(clk), .rstN(rstN), .runEn(runEn),
    .cfgCycleLen(cfgCycleLen), .cfgSwDelay(cfgSwDelay),
    .cfgPreLen(cfgPreLen), .cfgPayLen(cfgPayLen),
    .dataWord(dataWord), .swCtrl(swCtrl), .swLatch(swLatch), .cycleStart(cycleStart)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] refWord(input logic [30:0] s, output logic [30:0] nxt);
    logic [31:0] w = '0;
    logic [30:0] t = s;
    logic        b;
    for (int i = 0; i < 32; i++) begin
      b = t[30] ^ t[27];
      t = {t[29:0], b};
      w = {w[30:0], b};
    end
    nxt = t;
    return w;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s %s: actual=%h expected=%h", ctx, req, what, act, exp);
    end
  endtask

  task automatic setCfg(input int c, input int d, input int p, input int y);
    cfgCycleLen = 16'(c); cfgSwDelay = 16'(d); cfgPreLen = 16'(p); cfgPayLen = 16'(y);
  endtask

  // Check one word against the model; call right after a falling edge
  task automatic checkWord();
    logic [31:0] expD;
    logic [30:0] nx;
    string tag;
    if (k == 0) begin
      sCyc = (cfgCycleLen == 0) ? 1 : int'(cfgCycleLen);
      sSw = int'(cfgSwDelay); sPre = int'(cfgPreLen); sPay = int'(cfgPayLen);
      expSw = ~expSw;
    end
    if (k < sSw) begin
      expD = '0; tag = "R4";
    end else if (k < sSw + sPre) begin
      expD = 32'hAAAAAAAA; tag = "R5";
    end else if (k < sSw + sPre + sPay) begin
      if (k == sSw + sPre) pState = SEED;
      expD = refWord(pState, nx); pState = nx; tag = "R6";
    end else begin
      expD = '0; tag = "R7";
    end
    check(tag, "dataWord", dataWord, expD);
    check("R2", "cycleStart", {31'd0, cycleStart}, {31'd0, k == 0});
    check("R2", "swLatch", {31'd0, swLatch}, {31'd0, k == 0});
    check("R3", "swCtrl", {31'd0, swCtrl}, {31'd0, expSw});
    k = (k + 1 >= sCyc) ? 0 : k + 1;   // R8: index wraps at period
  endtask

  task automatic startRun();
    @(negedge clk);
    runEn = 1'b1;
    k = 0;
  endtask

  task automatic runWords(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkWord();
    end
  endtask

  task automatic stopRun(input int idleWords);
    runEn = 1'b0;
    for (int i = 0; i < idleWords; i++) begin
      @(negedge clk);
      check("R10", "idle dataWord", dataWord, 32'd0);
      check("R10", "idle strobes", {30'd0, swLatch, cycleStart}, 32'd0);
      check("R10", "idle swCtrl", {31'd0, swCtrl}, {31'd0, expSw});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset state
    ctx = "reset";
    setCfg(12, 2, 3, 4);
    runEn = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "dataWord", dataWord, 32'd0);
    check("R1", "swCtrl", {31'd0, swCtrl}, 32'd0);
    check("R1", "strobes", {30'd0, swLatch, cycleStart}, 32'd0);
    runEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      ctx = (v == 5) ? "R11" : ((v == 2 || v == 3) ? "R8" : "vec");
      setCfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      startRun();
      runWords(2 * ((VEC[v][0] == 0) ? 1 : VEC[v][0]) + 3);
      stopRun(2);
    end

    // R9: change settings part-way through a period
    ctx = "R9";
    setCfg(10, 1, 2, 3);
    startRun();
    runWords(4);
    setCfg(7, 0, 4, 2);
    runWords(6 + 7 + 7);
    stopRun(1);

    // R10: abort inside payload, then restart at word 0
    ctx = "R10";
    setCfg(12, 1, 1, 6);
    startRun();
    runWords(6);
    stopRun(3);
    startRun();
    runWords(13);
    stopRun(1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule